// File: doc/BRIEF.md
# Iterative Integer Multiplier with Overflow Trap

This unit takes two 64-bit operands, a 7-bit function code and a one-cycle start strobe. It forms the full 128-bit product over a fixed number of cycles with a radix-2 shift-add datapath. It then returns one 64-bit result, selected by the function code, together with an overflow flag and a one-cycle done pulse.

Five functions are provided:

- a signed 32-bit multiply whose result is sign-extended to 64 bits;
- the low 64 bits of a 64-bit multiply;
- the high 64 bits of an unsigned 64-bit multiply;
- trapping variants of the two signed multiplies.

A trapping variant raises the flag when the discarded upper bits are not all copies of the sign bit of the kept result.

The unit holds one operation at a time. A start that arrives while an operation is in flight is dropped. Result and flag keep their values until the next operation completes.

The 128-bit product is always formed as unsigned. For the 32-bit functions, the operands are first sign-extended from their low halves. The signed high half that the 64-bit trapping check needs is obtained by subtracting each operand from the unsigned high half when the other operand is negative.

Top module: `mul_trap_unit`

## Requirements
- R1: While reset is held and after its release, before any operation completes, `done`, `ovf` and `result` are all 0.
- R2: Function code 0x00 multiplies bits 31:0 of `a` and `b` as signed 32-bit values and returns bits 31:0 of the product sign-extended to 64 bits.
- R3: Function code 0x20 returns bits 63:0 of the product of `a` and `b`.
- R4: Function code 0x30 treats `a` and `b` as unsigned 64-bit values and returns bits 127:64 of their product.
- R5: Function code 0x40 returns the same result as code 0x00. It sets `ovf` unless bits 63:31 of the 64-bit signed product of the sign-extended low halves are all zeros or all ones.
- R6: Function code 0x60 returns bits 63:0 of the product. It sets `ovf` unless bits 127:63 of the 128-bit signed product of `a` and `b` are all zeros or all ones.
- R7: `done` is high for exactly one cycle. It rises XLEN+1 clock cycles after the rising edge at which `start` was accepted.
- R8: A `start` while an operation is in flight is ignored. The in-flight operation completes with its own operands and function code.
- R9: `result` and `ovf` keep their values from one completion until the next.
- R10: Function codes 0x00, 0x20 and 0x30 always complete with `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current `func`, `a`, `b` |
| func | input | 7 | Function code (0x00, 0x20, 0x30, 0x40, 0x60) |
| a | input | XLEN | First operand |
| b | input | XLEN | Second operand |
| result | output | XLEN | Selected half of the product |
| done | output | 1 | One-cycle pulse when `result` and `ovf` are updated |
| ovf | output | 1 | Overflow flag of the trapping functions |

## Verification
The hardest case to reach is the 64-bit trapping overflow boundary. Random operands almost never place the 128-bit signed product close to the edge of the 64-bit range. The stimulus therefore crosses a fixed set of extreme operands with each other under every function code: 0, 1, -1, the most negative and most positive 64-bit values, and the 32-bit sign boundaries. This covers the case where the unsigned high half needs both sign corrections. A second start is also pulsed in the middle of an operation, to show that it is dropped.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  localparam int FUNC_W = 7;
  typedef enum logic [FUNC_W-1:0] {
    FN_MUL32      = 7'h00,
    FN_MULLO      = 7'h20,
    FN_MULHU      = 7'h30,
    FN_MUL32_TRAP = 7'h40,
    FN_MULLO_TRAP = 7'h60
  } mul_fn_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   op_a,
  output logic [XLEN-1:0]   op_b
);
  localparam int HALF = XLEN / 2;

  logic narrow;

  always_comb begin
    narrow = (func == FN_MUL32) || (func == FN_MUL32_TRAP);
    if (narrow) begin
      op_a = {{HALF{a[HALF-1]}}, a[HALF-1:0]};
      op_b = {{HALF{b[HALF-1]}}, b[HALF-1:0]};
    end else begin
      op_a = a;
      op_b = b;
    end
  end
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     hi_q, hi_d, lo_q, lo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, fin_q, fin_d;
  logic [W:0]       addend, sum;

  always_comb begin
    addend = lo_q[0] ? {1'b0, mcand} : '0;
    sum    = {1'b0, hi_q} + addend;
    hi_d   = hi_q;
    lo_d   = lo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (load) begin
      hi_d   = '0;
      lo_d   = mplier;
      cnt_d  = CNT_W'(W - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      hi_d  = sum[W:1];
      lo_d  = {sum[0], lo_q[W-1:1]};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign busy    = busy_q;
  assign fin     = fin_q;
  assign prod_hi = hi_q;
  assign prod_lo = lo_q;

  // R7: completion comes straight out of an in-flight step, once
  assert_fin_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !busy_q && $past(busy_q));
  assert_fin_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/mul_result_sel.sv
module mul_result_sel
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [XLEN-1:0]   prod_hi,
  input  logic [XLEN-1:0]   prod_lo,
  output logic [XLEN-1:0]   result,
  output logic              ovf
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] corr_a, corr_b, hi_signed;
  logic [HALF:0]   narrow_top;
  logic            wide_ok, narrow_ok;

  always_comb begin
    corr_a     = opa[XLEN-1] ? opb : '0;
    corr_b     = opb[XLEN-1] ? opa : '0;
    hi_signed  = prod_hi - corr_a - corr_b;
    wide_ok    = ((hi_signed == '0) && !prod_lo[XLEN-1]) ||
                 ((hi_signed == '1) &&  prod_lo[XLEN-1]);
    narrow_top = prod_lo[XLEN-1:HALF-1];
    narrow_ok  = (narrow_top == '0) || (narrow_top == '1);
    ovf        = 1'b0;
    case (func)
      FN_MUL32:      result = {{HALF{prod_lo[HALF-1]}}, prod_lo[HALF-1:0]};
      FN_MUL32_TRAP: begin
        result = {{HALF{prod_lo[HALF-1]}}, prod_lo[HALF-1:0]};
        ovf    = !narrow_ok;
      end
      FN_MULHU:      result = prod_hi;
      FN_MULLO_TRAP: begin
        result = prod_lo;
        ovf    = !wide_ok;
      end
      default:       result = prod_lo;
    endcase
  end
endmodule

// File: rtl/mul_trap_unit.sv
module mul_trap_unit
  import mulu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   result,
  output logic              done,
  output logic              ovf
);
  logic [XLEN-1:0]   op_a, op_b, opa_q, opb_q, opa_d, opb_d;
  logic [FUNC_W-1:0] func_q, func_d;
  logic              busy, core_fin, accept;
  logic [XLEN-1:0]   prod_hi, prod_lo, sel_result;
  logic              sel_ovf;
  logic [XLEN-1:0]   result_q, result_d;
  logic              ovf_q, ovf_d, done_q, done_d;

  mul_operand_prep #(.XLEN(XLEN)) u_prep (
    .func(func), .a(a), .b(b), .op_a(op_a), .op_b(op_b)
  );

  mul_shift_add #(.W(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .mcand(opa_q), .mplier(op_b),
    .busy(busy), .fin(core_fin), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  mul_result_sel #(.XLEN(XLEN)) u_sel (
    .func(func_q), .opa(opa_q), .opb(opb_q), .prod_hi(prod_hi),
    .prod_lo(prod_lo), .result(sel_result), .ovf(sel_ovf)
  );

  always_comb begin
    accept   = start && !busy;
    opa_d    = accept ? op_a : opa_q;
    opb_d    = accept ? op_b : opb_q;
    func_d   = accept ? func : func_q;
    result_d = core_fin ? sel_result : result_q;
    ovf_d    = core_fin ? sel_ovf : ovf_q;
    done_d   = core_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q    <= '0;
      opb_q    <= '0;
      func_q   <= '0;
      result_q <= '0;
      ovf_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      opa_q    <= opa_d;
      opb_q    <= opb_d;
      func_q   <= func_d;
      result_q <= result_d;
      ovf_q    <= ovf_d;
      done_q   <= done_d;
    end
  end

  assign result = result_q;
  assign ovf    = ovf_q;
  assign done   = done_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> !done_q && !ovf_q && (result_q == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(func_q) && $stable(opa_q) && $stable(opb_q));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_fin |=> $stable(result_q) && $stable(ovf_q));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (func_q == FN_MUL32 || func_q == FN_MULLO || func_q == FN_MULHU))
    |-> !ovf_q);
endmodule

// File: tb/mul_trap_unit_tb.sv
module mul_trap_unit_tb;
  localparam int XLEN = 64;
  localparam int LAT  = XLEN + 2;

  logic            clk, rst_n, start;
  logic [6:0]      func;
  logic [XLEN-1:0] a, b, result;
  logic            done, ovf;

  int n_checks, n_fail;
  bit finished;

  mul_trap_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .a(a), .b(b),
    .result(result), .done(done), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [6:0] f, input logic [63:0] x,
                                 input logic [63:0] y, output logic [63:0] r,
                                 output logic v);
    logic signed [63:0]  p32;
    logic [127:0]        pu;
    logic signed [127:0] ps;
    p32 = $signed({{32{x[31]}}, x[31:0]}) * $signed({{32{y[31]}}, y[31:0]});
    pu  = {64'b0, x} * {64'b0, y};
    ps  = $signed({{64{x[63]}}, x}) * $signed({{64{y[63]}}, y});
    v = 1'b0;
    case (f)
      7'h00: r = {{32{p32[31]}}, p32[31:0]};
      7'h40: begin
        r = {{32{p32[31]}}, p32[31:0]};
        v = !((p32[63:31] == '0) || (p32[63:31] == '1));
      end
      7'h20: r = pu[63:0];
      7'h30: r = pu[127:64];
      default: begin
        r = ps[63:0];
        v = !((ps[127:63] == '0) || (ps[127:63] == '1));
      end
    endcase
  endfunction

  function automatic string rtag(input logic [6:0] f);
    case (f)
      7'h00: return "R2";
      7'h20: return "R3";
      7'h30: return "R4";
      7'h40: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Runs one operation; optional stray start at cycle 5 with other operands.
  task automatic run_op(input logic [6:0] f, input logic [63:0] x,
                        input logic [63:0] y, input bit stray);
    logic [63:0] er;
    logic        ev;
    int n;
    ref_op(f, x, y, er, ev);
    @(negedge clk);
    func = f; a = x; b = y; start = 1'b1;
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (stray && n == 5) begin
        start = 1'b1; func = 7'h30; a = ~x; b = 64'h3;
      end
      if (done || n > LAT + 10) break;
    end
    start = 1'b0;
    chk(n == LAT, "R7 latency", 64'(n), 64'(LAT));
    chk(result == er, stray ? "R8 stray start" : rtag(f), result, er);
    if (f == 7'h40 || f == 7'h60)
      chk(ovf == ev, f == 7'h40 ? "R5 ovf" : "R6 ovf", 64'(ovf), 64'(ev));
    else
      chk(ovf == 1'b0, "R10 ovf", 64'(ovf), 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R7 pulse width", 64'(done), 64'h0);
    repeat (3) @(negedge clk);
    chk(result == er && ovf == ev, "R9 hold", result, er);
  endtask

  logic [63:0] corner [9];
  logic [6:0]  fns [5];
  logic [63:0] seed;

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin
    n_checks = 0; n_fail = 0; finished = 1'b0;
    corner[0] = 64'h0;                corner[1] = 64'h1;
    corner[2] = '1;                   corner[3] = 64'h8000_0000_0000_0000;
    corner[4] = 64'h7fff_ffff_ffff_ffff; corner[5] = 64'h0000_0000_8000_0000;
    corner[6] = 64'h0000_0000_7fff_ffff; corner[7] = 64'hffff_ffff_8000_0000;
    corner[8] = 64'h0000_0001_0000_0000;
    fns[0] = 7'h00; fns[1] = 7'h20; fns[2] = 7'h30; fns[3] = 7'h40; fns[4] = 7'h60;
    rst_n = 1'b0; start = 1'b0; func = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    chk(done == 0 && ovf == 0 && result == '0, "R1 in reset", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 0 && ovf == 0 && result == '0, "R1 after release", result, '0);
    for (int fi = 0; fi < 5; fi++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          run_op(fns[fi], corner[i], corner[j], 1'b0);
    seed = 64'h9e37_79b9_7f4a_7c15;
    for (int k = 0; k < 200; k++) begin
      logic [63:0] x, y;
      seed = nxt(seed); x = seed;
      seed = nxt(seed); y = seed;
      if (k % 4 == 1) y = {32'h0, y[31:0]} >> (k % 31);
      if (k % 4 == 2) begin x = {{40{x[23]}}, x[23:0]}; y = {{40{y[23]}}, y[23:0]}; end
      run_op(fns[k % 5], x, y, 1'b0);
    end
    run_op(7'h20, 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 1'b1);
    run_op(7'h60, 64'h0000_0001_0000_0001, 64'h7fff_ffff_0000_0000, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R7 actual=%h expected=%h", 64'h0, 64'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule